// File: doc/BRIEF.md
# Scatter-Gather Segment Walker

This block sits in front of a hash datapath and decides which memory ranges that datapath must read. A start command selects one of two modes. In direct mode the block emits one segment built from the source base address and the 28-bit source length inputs. In list mode the source base address points to a chain of 8-byte descriptors in memory. The block reads each descriptor one 32-bit word at a time over a request/response memory port. It then emits the address/length pair that the descriptor describes.

Segments leave on a valid/ready channel. The last one carries a final marker. Once the downstream side accepts the final segment, the block pulses `done` for one cycle. It also shows how many segments were emitted in the walk. A list that never sets its final flag is cut off at a fixed entry limit, and the block then raises an overrun indication. Fetching the segment data, hashing and writing back the digest are done elsewhere.

Top module: `seglist_walker`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `overrun`, `seg_valid` and `mem_req_valid` are low and `seg_count` is zero.
- R2: In direct mode (`sg_mode`=0 at start), exactly one segment is emitted, with address `src_base`, length `src_len` and `seg_last`=1. No memory request is issued.
- R3: In list mode, the length word of descriptor i is requested at `src_base + 8*i` and its address word at `src_base + 8*i + 4`, in that order. Only one request is outstanding at a time: no new request is presented until the response to the previous one has arrived.
- R4: A segment's length is bits 27:0 of the descriptor's length word (bits 30:28 are ignored). Bit 31 of the length word marks the final descriptor, and that segment carries `seg_last`=1.
- R5: A segment's address is the descriptor's address word with bit 31 forced to zero.
- R6: A descriptor whose length field is zero is still emitted as a segment, and if it is not final the walk continues with the next descriptor.
- R7: At most `MAX_DESC` (default 256) descriptors are processed. If descriptor `MAX_DESC-1` lacks the final flag, it is emitted with `seg_last`=1, the walk stops and `overrun` goes high. `overrun` holds until the next accepted start clears it.
- R8: `done` is high for exactly one cycle, the cycle after the final segment is accepted. At that point `seg_count` equals the number of segments accepted in the walk.
- R9: A `start` that arrives while `busy` is high has no effect: the running walk completes unchanged and no extra walk follows.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged. While `seg_valid` is high and `seg_ready` is low, the segment fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk when idle |
| sg_mode | input | 1 | 1 = descriptor list, 0 = direct single segment |
| src_base | input | 32 | Direct segment address, or descriptor list base |
| src_len | input | 28 | Direct segment length |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Segment accepted downstream |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 28 | Segment length in bytes |
| seg_last | output | 1 | Final segment of the walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the final segment is accepted |
| overrun | output | 1 | Last walk hit the entry limit without a final flag |
| seg_count | output | 9 | Segments accepted in the current or last walk |

## Verification
The assertions check the handshake rules on every cycle: requests and segments stay stable under backpressure, and no second memory request appears while one is outstanding. They also check that `done` is a single pulse tied to the acceptance of a segment marked last, and that the segment count never exceeds the limit. Only the bench scenarios can show the data-dependent results. These include the descriptor addresses requested, the masking of the length and address words, zero-length entries inside a list, and the overrun cut-off at the entry limit versus a flag on that entry. They also include a stray start during a walk that is ignored.

// File: rtl/seglist_pkg.sv
package seglist_pkg;

    localparam int SL_ADDR_W     = 32;
    localparam int SL_WORD_W     = 32;
    localparam int SL_LEN_W      = 28;
    localparam int SL_FINAL_BIT  = 31;
    localparam int SL_ADDR_KEEP  = 31;
    localparam int SL_DESC_BYTES = 8;
    localparam int SL_HI_OFS     = 4;

    typedef enum logic [2:0] {
        WS_IDLE     = 3'd0,
        WS_LEN_REQ  = 3'd1,
        WS_LEN_WAIT = 3'd2,
        WS_ADR_REQ  = 3'd3,
        WS_ADR_WAIT = 3'd4,
        WS_EMIT     = 3'd5
    } walk_state_e;

    typedef struct packed {
        logic [SL_ADDR_W-1:0] addr;
        logic [SL_LEN_W-1:0]  len;
        logic                 last;
    } seg_t;

    function automatic logic [SL_ADDR_W-1:0] keep_addr(input logic [SL_WORD_W-1:0] w);
        return SL_ADDR_W'(w[SL_ADDR_KEEP-1:0]);
    endfunction

endpackage

// File: rtl/seglist_addr_gen.sv
module seglist_addr_gen
    import seglist_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [SL_ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 hi_word,
    output logic [SL_ADDR_W-1:0] req_addr
);
    localparam int SHIFT = $clog2(SL_DESC_BYTES);

    logic [SL_ADDR_W-1:0] entry_ofs;
    logic [SL_ADDR_W-1:0] word_ofs;

    assign entry_ofs = SL_ADDR_W'(idx) << SHIFT;
    assign word_ofs  = hi_word ? SL_ADDR_W'(SL_HI_OFS) : '0;
    assign req_addr  = base + entry_ofs + word_ofs;
endmodule

// File: rtl/seglist_desc_unpack.sv
module seglist_desc_unpack
    import seglist_pkg::*;
(
    input  logic [SL_WORD_W-1:0] word,
    output logic [SL_LEN_W-1:0]  len_field,
    output logic                 final_flag,
    output logic [SL_ADDR_W-1:0] addr_field
);
    assign len_field  = word[SL_LEN_W-1:0];
    assign final_flag = word[SL_FINAL_BIT];
    assign addr_field = keep_addr(word);
endmodule

// File: rtl/seglist_idx_ctr.sv
module seglist_idx_ctr #(
    parameter int MAX_DESC = 256,
    parameter int IDX_W    = 8,
    parameter int CNT_W    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] count,
    output logic             cap_hit
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx   <= '0;
            count <= '0;
        end else if (step) begin
            idx   <= idx + 1'b1;
            count <= count + 1'b1;
        end
    end

    assign cap_hit = (idx == IDX_W'(MAX_DESC - 1));
endmodule

// File: rtl/seglist_fsm.sv
module seglist_fsm
    import seglist_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 sg_mode,
    input  logic [SL_ADDR_W-1:0] src_base,
    input  logic [SL_LEN_W-1:0]  src_len,
    input  logic                 mem_req_ready,
    input  logic                 mem_rsp_valid,
    input  logic                 seg_ready,
    input  logic [SL_LEN_W-1:0]  d_len,
    input  logic                 d_final,
    input  logic [SL_ADDR_W-1:0] d_addr,
    input  logic                 cap_hit,
    output logic                 mem_req_valid,
    output logic                 hi_word,
    output logic [SL_ADDR_W-1:0] base_q,
    output seg_t                 seg_q,
    output logic                 seg_valid,
    output logic                 busy,
    output logic                 done,
    output logic                 overrun,
    output logic                 ctr_clear,
    output logic                 ctr_step
);
    walk_state_e         state;
    logic [SL_LEN_W-1:0] pend_len;
    logic                pend_final;
    logic                cut_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= WS_IDLE;
            base_q     <= '0;
            seg_q      <= '0;
            pend_len   <= '0;
            pend_final <= 1'b0;
            cut_q      <= 1'b0;
            done       <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                WS_IDLE: begin
                    if (start) begin
                        base_q  <= src_base;
                        overrun <= 1'b0;
                        cut_q   <= 1'b0;
                        if (sg_mode) begin
                            state <= WS_LEN_REQ;
                        end else begin
                            seg_q <= '{addr: src_base, len: src_len, last: 1'b1};
                            state <= WS_EMIT;
                        end
                    end
                end
                WS_LEN_REQ: begin
                    if (mem_req_ready) state <= WS_LEN_WAIT;
                end
                WS_LEN_WAIT: begin
                    if (mem_rsp_valid) begin
                        pend_len   <= d_len;
                        pend_final <= d_final;
                        state      <= WS_ADR_REQ;
                    end
                end
                WS_ADR_REQ: begin
                    if (mem_req_ready) state <= WS_ADR_WAIT;
                end
                WS_ADR_WAIT: begin
                    if (mem_rsp_valid) begin
                        seg_q <= '{addr: d_addr, len: pend_len, last: pend_final | cap_hit};
                        cut_q <= ~pend_final & cap_hit;
                        state <= WS_EMIT;
                    end
                end
                WS_EMIT: begin
                    if (seg_ready) begin
                        if (seg_q.last) begin
                            done    <= 1'b1;
                            overrun <= cut_q;
                            state   <= WS_IDLE;
                        end else begin
                            state <= WS_LEN_REQ;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state == WS_LEN_REQ) || (state == WS_ADR_REQ);
    assign hi_word       = (state == WS_ADR_REQ);
    assign seg_valid     = (state == WS_EMIT);
    assign busy          = (state != WS_IDLE);
    assign ctr_clear     = (state == WS_IDLE) && start;
    assign ctr_step      = (state == WS_EMIT) && seg_ready;
endmodule

// File: rtl/seglist_walker.sv
module seglist_walker
    import seglist_pkg::*;
#(
    parameter int MAX_DESC = 256,
    localparam int IDX_W   = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1,
    localparam int CNT_W   = $clog2(MAX_DESC + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 sg_mode,
    input  logic [SL_ADDR_W-1:0] src_base,
    input  logic [SL_LEN_W-1:0]  src_len,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [SL_ADDR_W-1:0] mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [SL_WORD_W-1:0] mem_rsp_data,
    output logic                 seg_valid,
    input  logic                 seg_ready,
    output logic [SL_ADDR_W-1:0] seg_addr,
    output logic [SL_LEN_W-1:0]  seg_len,
    output logic                 seg_last,
    output logic                 busy,
    output logic                 done,
    output logic                 overrun,
    output logic [CNT_W-1:0]     seg_count
);
    logic [SL_LEN_W-1:0]  d_len;
    logic                 d_final;
    logic [SL_ADDR_W-1:0] d_addr;
    logic [SL_ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]     idx;
    logic                 hi_word;
    logic                 cap_hit;
    logic                 ctr_clear;
    logic                 ctr_step;
    seg_t                 seg_q;

    seglist_desc_unpack u_unpack (
        .word       (mem_rsp_data),
        .len_field  (d_len),
        .final_flag (d_final),
        .addr_field (d_addr)
    );

    seglist_idx_ctr #(
        .MAX_DESC (MAX_DESC),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctr_clear),
        .step    (ctr_step),
        .idx     (idx),
        .count   (seg_count),
        .cap_hit (cap_hit)
    );

    seglist_addr_gen #(
        .IDX_W (IDX_W)
    ) u_agen (
        .base     (base_q),
        .idx      (idx),
        .hi_word  (hi_word),
        .req_addr (mem_req_addr)
    );

    seglist_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .sg_mode       (sg_mode),
        .src_base      (src_base),
        .src_len       (src_len),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .seg_ready     (seg_ready),
        .d_len         (d_len),
        .d_final       (d_final),
        .d_addr        (d_addr),
        .cap_hit       (cap_hit),
        .mem_req_valid (mem_req_valid),
        .hi_word       (hi_word),
        .base_q        (base_q),
        .seg_q         (seg_q),
        .seg_valid     (seg_valid),
        .busy          (busy),
        .done          (done),
        .overrun       (overrun),
        .ctr_clear     (ctr_clear),
        .ctr_step      (ctr_step)
    );

    assign seg_addr = seg_q.addr;
    assign seg_len  = seg_q.len;
    assign seg_last = seg_q.last;
endmodule

// File: rtl/seglist_walker_chk.sv
module seglist_walker_chk
    import seglist_pkg::*;
#(
    parameter int MAX_DESC = 256,
    parameter int CNT_W    = 9
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mem_req_valid,
    input logic                 mem_req_ready,
    input logic [SL_ADDR_W-1:0] mem_req_addr,
    input logic                 seg_valid,
    input logic                 seg_ready,
    input logic [SL_ADDR_W-1:0] seg_addr,
    input logic [SL_LEN_W-1:0]  seg_len,
    input logic                 seg_last,
    input logic                 busy,
    input logic                 done,
    input logic [CNT_W-1:0]     seg_count
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_seg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable({seg_addr, seg_len, seg_last}));

    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    assert_req_seg_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_valid && seg_valid));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        seg_valid && seg_ready && seg_last |=> done);

    assert_no_early_done_R8: assert property (@(posedge clk) disable iff (rst)
        seg_valid && seg_ready && !seg_last |=> !done);

    assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_count_limit_R7: assert property (@(posedge clk) disable iff (rst)
        int'(seg_count) <= MAX_DESC);
endmodule

bind seglist_walker seglist_walker_chk #(
    .MAX_DESC (MAX_DESC),
    .CNT_W    (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .seg_valid     (seg_valid),
    .seg_ready     (seg_ready),
    .seg_addr      (seg_addr),
    .seg_len       (seg_len),
    .seg_last      (seg_last),
    .busy          (busy),
    .done          (done),
    .seg_count     (seg_count)
);

// File: tb/seglist_walker_test.sv
`timescale 1ns/1ps
module seglist_walker_test;
    localparam int MAXD    = 256;
    localparam int RSP_LAT = 2;
    localparam int NVEC    = 6;

    // {sg_mode, base, len, list entries (0 = no final flag), expected segment count}
    localparam logic [96:0] VTAB [NVEC] = '{
        {1'b0, 32'h8000_1234, 32'h0ABC_DEF0, 16'd0, 16'd1},
        {1'b1, 32'h0000_1000, 32'h0000_0000, 16'd1, 16'd1},
        {1'b1, 32'h2000_0040, 32'h0000_0000, 16'd4, 16'd4},
        {1'b1, 32'hFFFF_FFF0, 32'h0000_0000, 16'd3, 16'd3},
        {1'b0, 32'h0000_0800, 32'h0000_0000, 16'd0, 16'd1},
        {1'b1, 32'h0000_0300, 32'h0000_0000, 16'd9, 16'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sg_mode = 1'b0;
    logic [31:0] src_base = '0;
    logic [27:0] src_len = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [31:0] seg_addr;
    logic [27:0] seg_len;
    logic        seg_last;
    logic        busy;
    logic        done;
    logic        overrun;
    logic [8:0]  seg_count;

    seglist_walker uut (
        .clk(clk), .rst(rst), .start(start), .sg_mode(sg_mode),
        .src_base(src_base), .src_len(src_len),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .busy(busy), .done(done), .overrun(overrun), .seg_count(seg_count)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // scenario state
    logic        cur_mode = 1'b0;
    logic [31:0] cur_base = '0;
    logic [31:0] cur_len = '0;
    int          list_n = 0;
    int          seg_idx = 0;
    int          req_i = 0;
    int          req_w = 0;
    int          req_total = 0;

    // memory model and sink state
    int          cyc_n = 0;
    int          pend = 0;
    logic [31:0] pend_addr = '0;
    logic        hold_pend = 1'b0;
    logic [31:0] h_addr = '0;
    logic [27:0] h_len = '0;
    logic        h_last = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] desc_len_word(input int i);
        logic [31:0] lw;
        lw = 32'((i * 37 + 5) & 32'hFFF);
        if ((i % 5) == 3) lw = '0;
        lw = lw | 32'h5000_0000;
        if (list_n != 0 && i == list_n - 1) lw = lw | 32'h8000_0000;
        return lw;
    endfunction

    function automatic logic [31:0] desc_addr_word(input int i);
        return 32'h8000_00A4 + 32'(i) * 32'h1000;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] off;
        off = a - cur_base;
        return off[2] ? desc_addr_word(int'(off >> 3)) : desc_len_word(int'(off >> 3));
    endfunction

    // memory responder, segment sink and per-transfer checks (all at negedge)
    always @(negedge clk) begin
        logic [31:0] ea;
        logic [27:0] el;
        logic        ela;
        logic [31:0] lw;
        cyc_n++;
        if (hold_pend) begin
            check(seg_valid && seg_addr == h_addr && seg_len == h_len && seg_last == h_last,
                  "R10", "segment held under backpressure",
                  {seg_valid, seg_addr, seg_len[26:0]}, {1'b1, h_addr, h_len[26:0]});
        end
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_addr);
            end
        end
        mem_req_ready = (cyc_n % 3) != 1;
        seg_ready     = (cyc_n % 4) != 2;
        if (mem_req_valid && mem_req_ready) begin
            if (!cur_mode) begin
                check(1'b0, "R2", "memory request in direct mode", 64'(mem_req_addr), 64'd0);
            end else begin
                check(pend == 0 && !mem_rsp_valid, "R3", "request while one outstanding",
                      64'(pend), 64'd0);
                check(mem_req_addr == cur_base + 32'(req_i) * 8 + 32'(req_w) * 4, "R3",
                      "descriptor word address", 64'(mem_req_addr),
                      64'(cur_base + 32'(req_i) * 8 + 32'(req_w) * 4));
            end
            if (req_w == 1) begin req_w = 0; req_i++; end else req_w = 1;
            req_total++;
            pend      = RSP_LAT;
            pend_addr = mem_req_addr;
        end
        hold_pend = seg_valid && !seg_ready;
        h_addr = seg_addr; h_len = seg_len; h_last = seg_last;
        if (seg_valid && seg_ready) begin
            if (!cur_mode) begin
                ea = cur_base; el = cur_len[27:0]; ela = 1'b1;
                check(seg_addr == ea && seg_len == el && seg_last == ela, "R2",
                      "direct segment", {seg_addr, seg_len, 3'b0, seg_last},
                      {ea, el, 3'b0, ela});
            end else begin
                lw  = desc_len_word(seg_idx);
                el  = lw[27:0];
                ea  = desc_addr_word(seg_idx) & 32'h7FFF_FFFF;
                ela = lw[31] || seg_idx == MAXD - 1;
                check(seg_len == el, (el == 0) ? "R6" : "R4", "segment length",
                      64'(seg_len), 64'(el));
                check(seg_addr == ea, "R5", "segment address masked", 64'(seg_addr), 64'(ea));
                check(seg_last == ela, (seg_idx == MAXD - 1) ? "R7" : "R4", "segment last marker",
                      64'(seg_last), 64'(ela));
            end
            seg_idx++;
        end
    end

    // watchdog
    int cyc_total = 0;
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_walk(input bit mode, input logic [31:0] base, input logic [31:0] len,
                            input int n, input int exp_cnt, input bit exp_err, input string tag);
        int t;
        @(posedge clk);
        cur_mode = mode; cur_base = base; cur_len = len; list_n = n;
        seg_idx = 0; req_i = 0; req_w = 0; req_total = 0;
        @(negedge clk);
        start = 1'b1; sg_mode = mode; src_base = base; src_len = len[27:0];
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, "R8", {tag, " done pulse seen"}, 64'(done), 64'd1);
        check(seg_count == 9'(exp_cnt), "R8", {tag, " segment count"}, 64'(seg_count), 64'(exp_cnt));
        check(seg_idx == exp_cnt, tag, "segments received", 64'(seg_idx), 64'(exp_cnt));
        check(overrun == exp_err, "R7", {tag, " overrun flag"}, 64'(overrun), 64'(exp_err));
        if (mode) begin
            check(req_total == 2 * exp_cnt, "R3", {tag, " word requests"},
                  64'(req_total), 64'(2 * exp_cnt));
        end
        @(negedge clk);
        check(done == 1'b0, "R8", {tag, " done lasts one cycle"}, 64'(done), 64'd0);
    endtask

    initial begin
        logic [96:0] e;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !overrun && !seg_valid && !mem_req_valid && seg_count == 0,
              "R1", "reset state",
              {busy, done, overrun, seg_valid, mem_req_valid, seg_count}, 64'd0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            e = VTAB[v];
            run_walk(e[96], e[95:64], e[63:32], int'(e[31:16]), int'(e[15:0]), 1'b0,
                     e[96] ? "R4" : "R2");
        end

        // R7: no final flag, cut at the entry limit
        run_walk(1'b1, 32'h0001_0000, 32'h0, 0, MAXD, 1'b1, "R7");
        // R7: a following walk clears the overrun flag
        run_walk(1'b1, 32'h0000_0500, 32'h0, 2, 2, 1'b0, "R7");
        // R7: final flag exactly on the last permitted entry
        run_walk(1'b1, 32'h0002_0000, 32'h0, MAXD, MAXD, 1'b0, "R7");

        // R9: start while busy is ignored
        @(posedge clk);
        cur_mode = 1'b1; cur_base = 32'h0000_4000; cur_len = '0; list_n = 5;
        seg_idx = 0; req_i = 0; req_w = 0; req_total = 0;
        @(negedge clk);
        start = 1'b1; sg_mode = 1'b1; src_base = 32'h0000_4000;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R9", "busy during walk", 64'(busy), 64'd1);
        start = 1'b1; sg_mode = 1'b0; src_base = 32'hDEAD_0000; src_len = 28'h10;
        repeat (3) @(negedge clk);
        start = 1'b0;
        begin
            int t;
            t = 0;
            while (!done && t < 20000) begin
                @(negedge clk);
                t++;
            end
        end
        check(seg_count == 9'd5, "R9", "walk count unchanged by stray start", 64'(seg_count), 64'd5);
        check(seg_idx == 5, "R9", "segments of running walk", 64'(seg_idx), 64'd5);
        repeat (12) @(negedge clk);
        check(seg_idx == 5 && !busy && !seg_valid, "R9", "no walk after stray start",
              {seg_idx[7:0], busy, seg_valid}, {8'd5, 2'b00});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule